// File: doc/BRIEF.md
# Read-Clock Phase Calibration Sequencer

This block centres a memory read clock inside its valid data window. It asks an external clock manager to move the fine phase one step up or down, and it asks an external memory tester to run a trial at the new phase. From the results it locates the lowest passing phase (the lower edge) and the first failing phase above the window (the upper edge). It then walks the phase back down to the midpoint of the two edges.

The scan has five stages. It descends until a trial fails. It climbs until a trial passes, which gives the lower edge. It climbs a further fixed guard distance without trials, to get clear of the unstable border. It climbs until a trial fails, which gives the upper edge. It then descends to the centre. An overflow flag from the clock manager counts as a failed trial in every decision. The sequencer assumes it starts inside the window or below it. A search stage that runs past a step limit without finding its edge stops the run with an error.

Top module: `phase_cal_seq`

## Requirements
- R1: A phase step is requested by holding `ps_en` high for exactly one cycle, with `ps_inc` (1 = increment, 0 = decrement) valid in that cycle. No further step or trial is requested until the one-cycle `ps_done` pulse for that step has arrived.
- R2: `phase_pos` is a signed counter that resets to 0. It moves by exactly one, in the requested direction, only in the cycle after the matching `ps_done` pulse.
- R3: After `cal_start` the sequencer steps down one step at a time, with one trial after each step, until a trial fails.
- R4: It then steps up, with one trial after each step, until a trial passes, and records that position in `edge_min`.
- R5: It then steps up exactly 10 times (the default guard count) without requesting any trial.
- R6: It then steps up, with one trial after each step, until a trial fails, and records that position in `edge_max`.
- R7: It then issues decrement steps only, until `phase_pos` equals (`edge_min` + `edge_max`) shifted arithmetically right by one (floor of the mean). It then raises `cal_done` with `cal_err` low.
- R8: A trial counts as failed when `trial_pass` is low or `ps_ovf` is high in the cycle of `trial_done`.
- R9: A trial is requested by a one-cycle `trial_start` pulse. The verdict is `trial_pass`, sampled in the cycle in which `trial_done` pulses. `trial_start` and `ps_en` are never high together.
- R10: If a search stage (R3, R4, R6) has made `STEP_LIMIT` steps and the trial after the last step still has not found its edge, the sequencer stops with `cal_err` and `cal_done` both high and issues no more requests.
- R11: While `rst_n` is low and after it is released, `ps_en`, `trial_start`, `cal_done` and `cal_err` are low and `phase_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Starts a calibration run (taken when idle or finished) |
| ps_en | output | 1 | One-cycle phase step request |
| ps_inc | output | 1 | Step direction, 1 = increment, 0 = decrement |
| ps_done | input | 1 | One-cycle step completion pulse |
| ps_ovf | input | 1 | Phase-shift overflow status, treated as a failure |
| trial_start | output | 1 | One-cycle memory trial request |
| trial_done | input | 1 | One-cycle trial completion pulse |
| trial_pass | input | 1 | Trial verdict, valid with `trial_done` |
| cal_done | output | 1 | Calibration finished (success or error) |
| cal_err | output | 1 | A search stage hit the step limit |
| phase_pos | output | POS_W | Signed phase position relative to reset |
| edge_min | output | POS_W | Recorded lower window edge |
| edge_max | output | POS_W | Recorded upper edge (first failing phase) |

## Verification
The bench builds the block with a 9-bit position, the default 10-step guard, and `STEP_LIMIT` lowered to 80. With the lower limit, a window that never passes runs into the error stop within a short run, while normal windows of 40 to 60 steps still finish. The modelled clock manager raises overflow above +60 and below -50. One run therefore finds its upper edge through overflow while the window still reports pass, and another finds its descending failure through overflow on the negative side, which ends on an odd negative sum for the midpoint. Other runs start below the window, and one uses a window narrower than the guard, so the upper search fails on its first step.

// File: rtl/pcal_pkg.sv
// Package: shared state and scan-stage types for the phase calibration sequencer.
// Assumes: nothing beyond standard SystemVerilog enum encoding.
package pcal_pkg;

    // Handshake state of the sequencer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP_REQ,
        ST_STEP_WAIT,
        ST_TRIAL_REQ,
        ST_TRIAL_WAIT,
        ST_DONE
    } seq_state_e;

    // Scan stage; the order is the order of the calibration run
    typedef enum logic [2:0] {
        SC_DESCEND,
        SC_FIND_LOW,
        SC_GUARD,
        SC_FIND_HIGH,
        SC_CENTRE
    } scan_stage_e;

endpackage

// File: rtl/pcal_pos_ctr.sv
// Module: signed phase position counter.
// What: moves the tracked phase by one in the given direction when bump is high.
// Assumes: bump is high for one cycle per completed step.
module pcal_pos_ctr #(
    parameter int POS_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bump,
    input  logic                    up,
    output logic signed [POS_W-1:0] pos
);

    // Track the phase position, one step per completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (bump)
            pos <= up ? pos + 1'b1 : pos - 1'b1;
    end

endmodule

// File: rtl/pcal_step_ctr.sv
// Module: step counter for the current scan stage.
// What: counts completed steps; clear has priority over increment.
// Assumes: the width covers the larger of the step limit and the guard count.
module pcal_step_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Count steps within one stage
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pcal_edge_regs.sv
// Module: window edge records and midpoint.
// What: stores the lower and upper edges and gives their floor mean.
// Assumes: each load is a single-cycle strobe taken from the position counter.
module pcal_edge_regs #(
    parameter int POS_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_low,
    input  logic                    load_high,
    input  logic signed [POS_W-1:0] pos,
    output logic signed [POS_W-1:0] edge_low,
    output logic signed [POS_W-1:0] edge_high,
    output logic signed [POS_W-1:0] centre
);

    localparam int SUM_W = POS_W + 1;

    logic signed [SUM_W-1:0] sum;

    // Capture the edges when the scan finds them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_low  <= '0;
            edge_high <= '0;
        end else begin
            if (load_low)  edge_low  <= pos;
            if (load_high) edge_high <= pos;
        end
    end

    // Floor mean of the two edges, without losing the carry
    always_comb begin
        sum    = SUM_W'(edge_low) + SUM_W'(edge_high);
        centre = POS_W'(sum >>> 1);
    end

endmodule

// File: rtl/pcal_fsm.sv
// Module: scan controller of the phase calibration sequencer.
// What: issues step and trial requests, decides stage changes, and flags the limit error.
// Assumes: the step completion and trial completion arrive as one-cycle pulses, and the
// run starts inside the data window or below it.
module pcal_fsm
    import pcal_pkg::*;
#(
    parameter int POS_W       = 9,
    parameter int CNT_W       = 8,
    parameter int STEP_LIMIT  = 200,
    parameter int GUARD_STEPS = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_start,
    input  logic                    ps_done,
    input  logic                    ps_ovf,
    input  logic                    trial_done,
    input  logic                    trial_pass,
    input  logic signed [POS_W-1:0] pos,
    input  logic signed [POS_W-1:0] centre,
    input  logic [CNT_W-1:0]        cnt,
    output logic                    ps_en,
    output logic                    ps_inc,
    output logic                    trial_start,
    output logic                    pos_bump,
    output logic                    cnt_clr,
    output logic                    load_low,
    output logic                    load_high,
    output logic                    cal_done,
    output logic                    cal_err
);

    seq_state_e  st, st_nx;
    scan_stage_e stage, stage_nx;
    logic        dir_nx, err_nx;
    logic        fail;
    logic        at_limit;
    logic        guard_last;
    logic signed [POS_W-1:0] pos_after;

    assign ps_en       = (st == ST_STEP_REQ);
    assign trial_start = (st == ST_TRIAL_REQ);
    assign cal_done    = (st == ST_DONE);
    assign pos_bump    = (st == ST_STEP_WAIT) && ps_done;

    // Verdict, stage limits and the position a pending step lands on
    always_comb begin
        fail       = !trial_pass || ps_ovf;
        at_limit   = (cnt == CNT_W'(STEP_LIMIT));
        guard_last = (cnt == CNT_W'(GUARD_STEPS - 1));
        pos_after  = ps_inc ? pos + 1'b1 : pos - 1'b1;
    end

    // Next-state decisions for the five-stage scan
    always_comb begin
        st_nx     = st;
        stage_nx  = stage;
        dir_nx    = ps_inc;
        err_nx    = cal_err;
        cnt_clr   = 1'b0;
        load_low  = 1'b0;
        load_high = 1'b0;
        case (st)
            ST_IDLE, ST_DONE: begin
                if (cal_start) begin
                    st_nx    = ST_STEP_REQ;
                    stage_nx = SC_DESCEND;
                    dir_nx   = 1'b0;
                    err_nx   = 1'b0;
                    cnt_clr  = 1'b1;
                end
            end
            ST_STEP_REQ: st_nx = ST_STEP_WAIT;
            ST_STEP_WAIT: begin
                if (ps_done) begin
                    case (stage)
                        SC_GUARD: begin
                            st_nx = ST_STEP_REQ;
                            if (guard_last) begin
                                stage_nx = SC_FIND_HIGH;
                                cnt_clr  = 1'b1;
                            end
                        end
                        SC_CENTRE: st_nx = (pos_after == centre) ? ST_DONE : ST_STEP_REQ;
                        default:   st_nx = ST_TRIAL_REQ;
                    endcase
                end
            end
            ST_TRIAL_REQ: st_nx = ST_TRIAL_WAIT;
            ST_TRIAL_WAIT: begin
                if (trial_done) begin
                    st_nx = ST_STEP_REQ;
                    if (stage == SC_DESCEND && fail) begin
                        stage_nx = SC_FIND_LOW;
                        dir_nx   = 1'b1;
                        cnt_clr  = 1'b1;
                    end else if (stage == SC_FIND_LOW && !fail) begin
                        stage_nx = SC_GUARD;
                        load_low = 1'b1;
                        cnt_clr  = 1'b1;
                    end else if (stage == SC_FIND_HIGH && fail) begin
                        stage_nx  = SC_CENTRE;
                        load_high = 1'b1;
                        dir_nx    = 1'b0;
                        cnt_clr   = 1'b1;
                    end else if (at_limit) begin
                        st_nx  = ST_DONE;
                        err_nx = 1'b1;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State, stage, direction and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            stage   <= SC_DESCEND;
            ps_inc  <= 1'b0;
            cal_err <= 1'b0;
        end else begin
            st      <= st_nx;
            stage   <= stage_nx;
            ps_inc  <= dir_nx;
            cal_err <= err_nx;
        end
    end

    // R1: the step request lasts one cycle
    assert_step_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ps_en |=> !ps_en);

    // R1: no new request while a step is outstanding
    assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STEP_WAIT && !ps_done) |=> !ps_en && !trial_start);

    // R2: a completed step always moves the position
    assert_pos_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STEP_WAIT && ps_done) |=> pos != $past(pos));

    // R2: the position holds when no completion arrives
    assert_pos_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_done |=> $stable(pos));

    // R9: the trial request lasts one cycle and never overlaps a step request
    assert_trial_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trial_start |=> !trial_start);
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trial_start && ps_en));

    // R10: an error always comes with the finished flag
    assert_err_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |-> cal_done);

endmodule

// File: rtl/phase_cal_seq.sv
// Module: phase calibration sequencer (top).
// What: centres a read clock in its data window by stepping a clock manager's fine
// phase and running memory trials; records both edges and settles on the midpoint.
// Assumes: one-cycle completion pulses from the clock manager and the memory tester,
// a start inside or below the window, and a guard count of at least one.
module phase_cal_seq #(
    parameter int POS_W       = 9,
    parameter int STEP_LIMIT  = 200,
    parameter int GUARD_STEPS = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_start,
    output logic                    ps_en,
    output logic                    ps_inc,
    input  logic                    ps_done,
    input  logic                    ps_ovf,
    output logic                    trial_start,
    input  logic                    trial_done,
    input  logic                    trial_pass,
    output logic                    cal_done,
    output logic                    cal_err,
    output logic signed [POS_W-1:0] phase_pos,
    output logic signed [POS_W-1:0] edge_min,
    output logic signed [POS_W-1:0] edge_max
);

    localparam int CNT_MAX = (STEP_LIMIT > GUARD_STEPS) ? STEP_LIMIT : GUARD_STEPS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic                    pos_bump, cnt_clr, load_low, load_high;
    logic [CNT_W-1:0]        cnt;
    logic signed [POS_W-1:0] centre;

    pcal_fsm #(
        .POS_W(POS_W), .CNT_W(CNT_W),
        .STEP_LIMIT(STEP_LIMIT), .GUARD_STEPS(GUARD_STEPS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .ps_done(ps_done), .ps_ovf(ps_ovf),
        .trial_done(trial_done), .trial_pass(trial_pass),
        .pos(phase_pos), .centre(centre), .cnt(cnt),
        .ps_en(ps_en), .ps_inc(ps_inc), .trial_start(trial_start),
        .pos_bump(pos_bump), .cnt_clr(cnt_clr),
        .load_low(load_low), .load_high(load_high),
        .cal_done(cal_done), .cal_err(cal_err)
    );

    pcal_pos_ctr #(.POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .bump(pos_bump), .up(ps_inc), .pos(phase_pos)
    );

    pcal_step_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(pos_bump), .cnt(cnt)
    );

    pcal_edge_regs #(.POS_W(POS_W)) u_edges (
        .clk(clk), .rst_n(rst_n), .load_low(load_low), .load_high(load_high),
        .pos(phase_pos), .edge_low(edge_min), .edge_high(edge_max), .centre(centre)
    );

    // R7: a successful run ends with the upper edge above the lower one
    assert_edge_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_err) |-> edge_max > edge_min);

    // R8: an overflowed trial never records the lower edge
    assert_ovf_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_done && ps_ovf) |=> $stable(edge_min));

endmodule

// File: tb/test_phase_cal_seq.sv
// Bench: behavioural clock manager and memory tester, a per-cycle position and protocol
// comparison, and a per-run prediction of edges, final phase, step and trial counts.
module test_phase_cal_seq;

    localparam int POS_W   = 9;
    localparam int LIMIT   = 80;
    localparam int GUARD   = 10;
    localparam int OVF_HI  = 60;
    localparam int OVF_LO  = -50;
    localparam int STEP_LAT  = 2;
    localparam int TRIAL_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic ps_en, ps_inc, trial_start, cal_done, cal_err;
    logic ps_done = 1'b0, ps_ovf = 1'b0, trial_done = 1'b0, trial_pass = 1'b0;
    logic signed [POS_W-1:0] phase_pos, edge_min, edge_max;

    int errors = 0;
    int checks = 0;

    // environment model state
    int phase = 0;
    int win_lo = 0, win_hi = 0;
    int ps_cnt = 0, tr_cnt = 0;
    int pend_dir = 0;
    int n_steps = 0, n_trials = 0;
    int n_guard_trials = 0;
    int ups_since_low = -1;
    bit prev_en = 0, prev_tr = 0;

    always #10 clk = ~clk;

    phase_cal_seq #(.POS_W(POS_W), .STEP_LIMIT(LIMIT), .GUARD_STEPS(GUARD)) i_phase_cal_seq (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .ps_en(ps_en), .ps_inc(ps_inc), .ps_done(ps_done), .ps_ovf(ps_ovf),
        .trial_start(trial_start), .trial_done(trial_done), .trial_pass(trial_pass),
        .cal_done(cal_done), .cal_err(cal_err),
        .phase_pos(phase_pos), .edge_min(edge_min), .edge_max(edge_max)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ok_at(input int p);
        return (p >= win_lo) && (p <= win_hi) && (p <= OVF_HI) && (p >= OVF_LO);
    endfunction

    // Predicted outcome of one run from the requirements
    function automatic void predict(output int lo_e, output int hi_e, output int fin,
                                    output bit err, output int steps, output int trials);
        int p = 0;
        int n;
        lo_e = 0; hi_e = 0; err = 0; steps = 0; trials = 0;
        n = 0;
        forever begin
            p--; steps++; n++; trials++;
            if (!ok_at(p)) break;
            if (n == LIMIT) begin err = 1; fin = p; return; end
        end
        n = 0;
        forever begin
            p++; steps++; n++; trials++;
            if (ok_at(p)) begin lo_e = p; break; end
            if (n == LIMIT) begin err = 1; fin = p; return; end
        end
        for (int i = 0; i < GUARD; i++) begin p++; steps++; end
        n = 0;
        forever begin
            p++; steps++; n++; trials++;
            if (!ok_at(p)) begin hi_e = p; break; end
            if (n == LIMIT) begin err = 1; fin = p; return; end
        end
        while (p > ((lo_e + hi_e) >>> 1)) begin p--; steps++; end
        fin = p;
    endfunction

    // Clock manager, memory tester and per-cycle comparison, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                phase = 0; ps_cnt = 0; tr_cnt = 0; ps_done = 0; trial_done = 0;
                prev_en = 0; prev_tr = 0;
            end else begin
                // R1 R9: pulses are one cycle wide
                if (prev_en && ps_en) chk(0, "R1 ps_en width", 2, 1);
                if (prev_tr && trial_start) chk(0, "R9 trial_start width", 2, 1);
                if (ps_en && trial_start) chk(0, "R9 overlap", 1, 0);
                // R1: one outstanding request
                if ((ps_en || trial_start) && (ps_cnt > 0 || tr_cnt > 0))
                    chk(0, "R1 request while busy", 1, 0);
                if (ps_done) begin
                    ps_done = 0;
                    phase += pend_dir;
                    if (pend_dir > 0 && ups_since_low >= 0) ups_since_low++;
                end
                if (trial_done) trial_done = 0;
                if (ps_cnt > 0) begin ps_cnt--; if (ps_cnt == 0) ps_done = 1; end
                if (tr_cnt > 0) begin
                    tr_cnt--;
                    if (tr_cnt == 0) begin
                        trial_done = 1;
                        trial_pass = (phase >= win_lo) && (phase <= win_hi);
                    end
                end
                if (ps_en) begin
                    pend_dir = ps_inc ? 1 : -1;
                    ps_cnt = STEP_LAT;
                    n_steps++;
                end
                if (trial_start) begin
                    tr_cnt = TRIAL_LAT;
                    n_trials++;
                    // R5: no trial during the guard climb (after the low edge, fewer than GUARD ups)
                    if (ups_since_low >= 0 && ups_since_low < GUARD) n_guard_trials++;
                    if (ups_since_low < 0 && phase == int'(edge_min) && edge_min != 0) ups_since_low = -1;
                end
                ps_ovf = (phase > OVF_HI) || (phase < OVF_LO);
                prev_en = ps_en; prev_tr = trial_start;
                // R2: the position follows the completed steps
                chk(int'(phase_pos) == phase, "R2 phase_pos", int'(phase_pos), phase);
            end
        end
    end

    // Mark the start of the guard climb when a passing trial is seen in the upward search
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) ups_since_low = -1;
            else if (trial_done && trial_pass && !ps_ovf && pend_dir > 0 && ups_since_low < 0)
                ups_since_low = 0;
        end
    end

    task automatic run(input int lo, input int hi, input string tag);
        int e_lo, e_hi, e_fin, e_steps, e_trials;
        bit e_err;
        int waited;
        win_lo = lo; win_hi = hi;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset
        chk(!ps_en && !trial_start && !cal_done && !cal_err && phase_pos == 0,
            "R11 in reset", {ps_en, trial_start, cal_done, cal_err}, 0);
        rst_n = 1;
        @(negedge clk);
        n_steps = 0; n_trials = 0; n_guard_trials = 0;
        chk(!ps_en && !trial_start && !cal_done && !cal_err && phase_pos == 0,
            "R11 after reset", {ps_en, trial_start, cal_done, cal_err}, 0);
        cal_start = 1;
        @(negedge clk);
        cal_start = 0;
        waited = 0;
        while (!cal_done && waited < 20000) begin @(negedge clk); waited++; end
        chk(waited < 20000, {"watchdog ", tag}, waited, 20000);
        repeat (6) @(negedge clk);
        predict(e_lo, e_hi, e_fin, e_err, e_steps, e_trials);
        $display("run %s: lo=%0d hi=%0d", tag, e_lo, e_hi);
        chk(cal_done == 1, {"R7 R10 done ", tag}, cal_done, 1);
        chk(cal_err == e_err, {"R10 err ", tag}, cal_err, e_err);
        chk(int'(phase_pos) == e_fin, {"R7 final phase ", tag}, phase_pos, e_fin);
        if (!e_err) begin
            chk(int'(edge_min) == e_lo, {"R3 R4 edge_min ", tag}, edge_min, e_lo);
            chk(int'(edge_max) == e_hi, {"R6 R8 edge_max ", tag}, edge_max, e_hi);
        end
        chk(n_steps == e_steps, {"R5 step count ", tag}, n_steps, e_steps);
        chk(n_trials == e_trials, {"R9 trial count ", tag}, n_trials, e_trials);
        chk(n_guard_trials == 0, {"R5 guard trials ", tag}, n_guard_trials, 0);
        chk(!ps_en && !trial_start, {"R10 quiet when done ", tag}, {ps_en, trial_start}, 0);
    endtask

    initial begin
        run(-7, 20, "inside");          // R3 R4 R6 R7
        run(5, 30, "below");            // R3: first step already fails
        run(-2, 3, "narrow");           // R6: fails on first step after guard
        run(-5, 200, "ovf_high");       // R8: window passes, overflow fails at 61
        run(-150, 10, "ovf_low");       // R8: overflow at -51, odd negative midpoint
        run(100, 90, "no_window");      // R10: upward search exhausts the limit
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule